// File: doc/BRIEF.md
# Run-Time Configurable Serial Character Transmitter

This block turns one parallel character into an asynchronous serial frame on an idle-high line. A host raises a one-cycle write strobe with the character on the data bus; the block drops the line for a start bit, shifts the data out least significant bit first, optionally appends a parity bit, and closes with one or two high stop bits. The bit rate is not generated here. A separate rate generator supplies a one-cycle `bit_tick` pulse at every bit boundary, and every bit after the start bit spans exactly one tick interval.

The frame shape is chosen at run time by four static inputs: data length (7 or 8 bits), parity on or off, parity sense (even or odd) and stop count (1 or 2). These inputs are captured, together with the character, when a write is accepted. A busy flag tells the host when the next write may be issued. Writes that arrive while busy is high are dropped. Clearing `run_en` stops the transmitter at once: the line returns high, busy clears, and writes are ignored for as long as `run_en` stays low.

Top module: `uart_frame_tx`

## Requirements
- R1: After reset, and whenever no character is in flight, `tx_line` is 1 and `tx_busy` is 0.
- R2: A write strobe sampled with `run_en`=1 and `tx_busy`=0 makes `tx_busy` 1 and `tx_line` 0 (the start bit) in the next cycle. The start bit lasts until the first `bit_tick` after the write.
- R3: After the start bit, the data bits appear least significant bit first, each lasting exactly one tick interval. When `fmt_long`=1, bits 0 to 7 are sent. When `fmt_long`=0, bits 0 to 6 are sent and bit 7 has no effect on the frame.
- R4: When `par_en`=1, one parity bit follows the data. With `par_odd`=0, the number of ones across the data and parity bits is even; with `par_odd`=1 it is odd. When `par_en`=0, no parity bit is sent and `par_odd` has no effect.
- R5: The frame ends with one high stop bit when `stop_two`=0, or two when `stop_two`=1, each lasting one tick interval.
- R6: `tx_busy` falls in the cycle after the tick that ends the last stop bit. A write in that cycle drives the next start bit in the following cycle, so no extra idle bit is inserted between frames.
- R7: A write strobe while `tx_busy`=1 is ignored, and the frame in flight is unchanged.
- R8: With `run_en`=0, `tx_line` is 1 and `tx_busy` is 0 in the next cycle. A frame in progress is abandoned, and write strobes are ignored.
- R9: The format inputs are captured at the accepted write. Changing them during a frame does not alter that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| run_en | input | 1 | Transmitter enable; 0 forces idle and aborts |
| fmt_long | input | 1 | 1: DATA_W data bits, 0: DATA_W-1 data bits |
| par_en | input | 1 | 1: append parity bit |
| par_odd | input | 1 | 0: even parity, 1: odd parity |
| stop_two | input | 1 | 0: one stop bit, 1: two stop bits |
| bit_tick | input | 1 | One-cycle pulse at each bit boundary |
| wr_stb | input | 1 | One-cycle write strobe |
| wr_data | input | DATA_W | Character to send |
| tx_line | output | 1 | Serial output, idle high |
| tx_busy | output | 1 | High while a character is in flight |

## Verification
Both outputs are registered. A write, a tick or a change of `run_en` sampled at one rising edge shows up at the ports right after that edge. The bench drives its inputs and reads the outputs on falling edges, and it records whether a tick was present at the preceding rising edge. It advances its expected bit index only after an edge that carried a tick, and compares the line against its own frame built from the requirements on every cycle of the frame. Busy must then read low on the falling edge just after the tick that ends the last stop bit, and a write issued in that same half cycle must show the start bit on the very next falling edge.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

   typedef struct packed {
      logic long_fmt;
      logic par_en;
      logic par_odd;
      logic stop_two;
   } tx_fmt_t;

   function automatic int frame_bits_max(input int data_w);
      return 1 + data_w + 1 + 2;
   endfunction

endpackage

// File: rtl/uart_tx_parity.sv
module uart_tx_parity #(
   parameter int DATA_W = 8
) (
   input  logic [DATA_W-1:0] data,
   input  logic              long_fmt,
   input  logic              odd,
   output logic              par_bit
);
   logic [DATA_W-1:0] masked;

   for (genvar g = 0; g < DATA_W; g++) begin : g_mask
      if (g == DATA_W - 1) begin : g_top
         assign masked[g] = data[g] & long_fmt;
      end else begin : g_low
         assign masked[g] = data[g];
      end
   end

   // even sense: parity equals XOR of data, making the total count even
   assign par_bit = (^masked) ^ odd;
endmodule

// File: rtl/uart_tx_framer.sv
module uart_tx_framer
   import uart_tx_pkg::*;
#(
   parameter int DATA_W  = 8,
   parameter int FRAME_W = 12,
   parameter int CNT_W   = 4
) (
   input  logic [DATA_W-1:0]  data,
   input  tx_fmt_t            fmt,
   output logic [FRAME_W-1:0] frame,
   output logic [CNT_W-1:0]   nbits
);
   logic             par_bit;
   logic [CNT_W-1:0] dlen;

   uart_tx_parity #(.DATA_W(DATA_W)) u_par (
      .data     (data),
      .long_fmt (fmt.long_fmt),
      .odd      (fmt.par_odd),
      .par_bit  (par_bit)
   );

   assign dlen = fmt.long_fmt ? CNT_W'(DATA_W) : CNT_W'(DATA_W - 1);

   always_comb begin
      frame    = '1;
      frame[0] = 1'b0;
      for (int i = 0; i < DATA_W; i++) begin
         if (i < int'(dlen)) frame[1 + i] = data[i];
      end
      if (fmt.par_en) frame[int'(dlen) + 1] = par_bit;
   end

   assign nbits = CNT_W'(1) + dlen + CNT_W'(fmt.par_en)
                + (fmt.stop_two ? CNT_W'(2) : CNT_W'(1));
endmodule

// File: rtl/uart_tx_shifter.sv
module uart_tx_shifter #(
   parameter int FRAME_W = 12,
   parameter int CNT_W   = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               run_en,
   input  logic               bit_tick,
   input  logic               load,
   input  logic [FRAME_W-1:0] frame,
   input  logic [CNT_W-1:0]   nbits,
   output logic               line_q,
   output logic               busy_q
);
   logic [FRAME_W-1:0] shreg;
   logic [CNT_W-1:0]   left;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         line_q <= 1'b1;
         busy_q <= 1'b0;
         shreg  <= '1;
         left   <= '0;
      end else if (!run_en) begin
         line_q <= 1'b1;
         busy_q <= 1'b0;
         left   <= '0;
      end else if (!busy_q) begin
         if (load) begin
            busy_q <= 1'b1;
            line_q <= frame[0];
            shreg  <= {1'b1, frame[FRAME_W-1:1]};
            left   <= nbits - CNT_W'(1);
         end
      end else if (bit_tick) begin
         if (left == '0) begin
            busy_q <= 1'b0;
            line_q <= 1'b1;
         end else begin
            line_q <= shreg[0];
            shreg  <= {1'b1, shreg[FRAME_W-1:1]};
            left   <= left - CNT_W'(1);
         end
      end
   end
endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx
   import uart_tx_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run_en,
   input  logic              fmt_long,
   input  logic              par_en,
   input  logic              par_odd,
   input  logic              stop_two,
   input  logic              bit_tick,
   input  logic              wr_stb,
   input  logic [DATA_W-1:0] wr_data,
   output logic              tx_line,
   output logic              tx_busy
);
   localparam int FRAME_W = frame_bits_max(DATA_W);
   localparam int CNT_W   = $clog2(FRAME_W + 1);

   if (DATA_W < 2) begin : g_bad_width
      $error("uart_frame_tx: DATA_W must be at least 2");
   end

   tx_fmt_t            fmt;
   logic [FRAME_W-1:0] frame;
   logic [CNT_W-1:0]   nbits;

   assign fmt = '{long_fmt: fmt_long, par_en: par_en, par_odd: par_odd, stop_two: stop_two};

   uart_tx_framer #(.DATA_W(DATA_W), .FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_frm (
      .data  (wr_data),
      .fmt   (fmt),
      .frame (frame),
      .nbits (nbits)
   );

   uart_tx_shifter #(.FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_shf (
      .clk      (clk),
      .rst_n    (rst_n),
      .run_en   (run_en),
      .bit_tick (bit_tick),
      .load     (wr_stb),
      .frame    (frame),
      .nbits    (nbits),
      .line_q   (tx_line),
      .busy_q   (tx_busy)
   );
endmodule

// File: rtl/uart_tx_chk.sv
module uart_tx_chk (
   input logic clk,
   input logic rst_n,
   input logic run_en,
   input logic bit_tick,
   input logic wr_stb,
   input logic tx_line,
   input logic tx_busy
);
   p_idle_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_busy |-> tx_line);

   p_start_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (run_en && wr_stb && !tx_busy) |=> (tx_busy && !tx_line));

   p_hold_bit_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (run_en && tx_busy && !bit_tick) |=> $stable(tx_line));

   p_busy_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (run_en && tx_busy && !bit_tick) |=> tx_busy);

   p_busy_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(tx_busy) |-> ($past(bit_tick) || !$past(run_en)));

   p_run_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !run_en |=> (!tx_busy && tx_line));
endmodule

bind uart_frame_tx uart_tx_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .run_en   (run_en),
   .bit_tick (bit_tick),
   .wr_stb   (wr_stb),
   .tx_line  (tx_line),
   .tx_busy  (tx_busy)
);

// File: tb/sim_uart_frame_tx.sv
module sim_uart_frame_tx;
   localparam int TPER = 6;

   logic clk = 0, rst_n = 0;
   logic run_en = 1, fmt_long = 1, par_en = 0, par_odd = 0, stop_two = 0;
   logic bit_tick = 0, wr_stb = 0;
   logic [7:0] wr_data = '0;
   logic tx_line, tx_busy;
   logic tick_at_edge = 0;
   int   tcnt = 0;
   int   n_chk = 0, n_bad = 0;
   bit   done = 0;

   always #2 clk = ~clk;

   uart_frame_tx #(.DATA_W(8)) u0 (
      .clk(clk), .rst_n(rst_n), .run_en(run_en), .fmt_long(fmt_long),
      .par_en(par_en), .par_odd(par_odd), .stop_two(stop_two),
      .bit_tick(bit_tick), .wr_stb(wr_stb), .wr_data(wr_data),
      .tx_line(tx_line), .tx_busy(tx_busy));

   always @(negedge clk) begin
      tcnt     = (tcnt == TPER - 1) ? 0 : tcnt + 1;
      bit_tick = (tcnt == TPER - 1);
   end
   always @(posedge clk) tick_at_edge = bit_tick;

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic void build(input logic [7:0] d, input logic lg, pe, po, ts,
                                 output logic [15:0] f, output int n);
      int dl = lg ? 8 : 7;
      logic p = 1'b0;
      f = '1; f[0] = 1'b0; n = 1;
      for (int i = 0; i < dl; i++) begin f[n] = d[i]; p ^= d[i]; n++; end
      if (pe) begin f[n] = po ? ~p : p; n++; end
      n += ts ? 2 : 1;
   endfunction

   // Called at a falling edge; ends at the falling edge where busy is low.
   task automatic send_frame(input logic [7:0] d, input logic lg, pe, po, ts,
                             input int poke, input bit flip, input string req);
      logic [15:0] f; int n, idx = 0, guard = 0, mis_i = -1, mis_a = 0;
      bit pk = 0, ok = 1;
      build(d, lg, pe, po, ts, f, n);
      fmt_long = lg; par_en = pe; par_odd = po; stop_two = ts;
      wr_data = d; wr_stb = 1;
      @(negedge clk); wr_stb = 0;
      chk(tx_line === 1'b0 && tx_busy === 1'b1, "R2", "start bit line", tx_line, 0);
      while (1) begin
         if (tx_line !== f[idx] || tx_busy !== 1'b1) begin
            if (ok) begin mis_i = idx; mis_a = tx_line; end
            ok = 0;
         end
         if (idx == poke && !pk) begin
            pk = 1; wr_stb = 1; wr_data = ~d;
            if (flip) begin
               fmt_long = ~lg; par_en = ~pe; par_odd = ~po; stop_two = ~ts;
            end
         end
         @(negedge clk); wr_stb = 0; guard++;
         if (tick_at_edge) idx++;
         if (idx == n || guard > 500) break;
      end
      chk(ok, req, $sformatf("frame bits (first bad index %0d)", mis_i),
          mis_a, (mis_i >= 0) ? int'(f[mis_i]) : 0);
      chk(tx_busy === 1'b0 && tx_line === 1'b1, "R6", "busy low after last stop",
          tx_busy, 0);
      fmt_long = lg; par_en = pe; par_odd = po; stop_two = ts;
   endtask

   task automatic t_reset();
      bit ok = 1;
      repeat (20) begin
         @(negedge clk);
         if (tx_line !== 1'b1 || tx_busy !== 1'b0) ok = 0;
      end
      chk(ok, "R1", "idle line/busy after reset", tx_line, 1);
   endtask

   task automatic t_formats();
      @(negedge clk); send_frame(8'hA5, 1, 0, 0, 0, -1, 0, "R3");
      @(negedge clk); send_frame(8'hB6, 0, 1, 0, 0, -1, 0, "R3 R4");
      @(negedge clk); send_frame(8'h3C, 1, 1, 1, 1, -1, 0, "R4 R5");
      @(negedge clk); send_frame(8'h81, 0, 1, 1, 0, -1, 0, "R4");
      @(negedge clk); send_frame(8'h5B, 1, 1, 0, 1, -1, 0, "R4 R5");
      @(negedge clk); send_frame(8'h6E, 1, 0, 1, 1, -1, 0, "R4 R5");
   endtask

   task automatic t_back_to_back();
      @(negedge clk);
      send_frame(8'h0F, 1, 0, 0, 0, -1, 0, "R6");
      send_frame(8'hF0, 1, 1, 0, 0, -1, 0, "R6");
      send_frame(8'h7F, 0, 0, 0, 1, -1, 0, "R6");
   endtask

   task automatic t_write_busy();
      @(negedge clk); send_frame(8'h96, 1, 1, 1, 1, 3, 0, "R7");
      @(negedge clk); send_frame(8'h2D, 0, 1, 0, 0, 2, 1, "R9");
   endtask

   task automatic t_run_off();
      bit ok = 1;
      @(negedge clk);
      fmt_long = 1; par_en = 0; stop_two = 0; wr_data = 8'h00; wr_stb = 1;
      @(negedge clk); wr_stb = 0;
      repeat (2 * TPER + 2) @(negedge clk);
      run_en = 0;
      @(negedge clk);
      chk(tx_line === 1'b1 && tx_busy === 1'b0, "R8", "abort to idle", tx_busy, 0);
      wr_data = 8'h00; wr_stb = 1;
      @(negedge clk); wr_stb = 0;
      repeat (3 * TPER) begin
         @(negedge clk);
         if (tx_line !== 1'b1 || tx_busy !== 1'b0) ok = 0;
      end
      run_en = 1;
      repeat (3 * TPER) begin
         @(negedge clk);
         if (tx_line !== 1'b1 || tx_busy !== 1'b0) ok = 0;
      end
      chk(ok, "R8", "write ignored while run low", tx_busy, 0);
      send_frame(8'hC3, 1, 1, 0, 0, -1, 0, "R8 recovery");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      t_reset();
      t_formats();
      t_back_to_back();
      t_write_busy();
      t_run_off();
      t_reset();
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual hung expected done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule